// File: doc/BRIEF.md
# Cache Way Lockdown Victim Selector

This block chooses the destination way for every linefill of a four-way set-associative cache that has separate data and instruction sides. Each side has a lock mask with one bit per way. A set bit keeps normal allocation out of that way. Software can then pin critical lines in the cache, or keep one task from evicting the lines of another. The masks are reached through a small coprocessor-style register port: a 3-bit select picks the register, and a write strobe stores the low four bits of the write data.

Each side has a 2-bit round-robin counter. On a linefill request the block returns, in the same cycle, the first unlocked way found by searching upward from the counter with wraparound. On the next clock edge the counter moves to the way just after the chosen one. If every way on a side is locked, that side's fills go to way 3. The data and instruction paths share no state.

Top module: `way_lock_victim_sel`

## Requirements
- R1: After reset both lock masks read back as 0 (all ways open) and both round-robin counters are 0, so the first fill on each side gets way 0.
- R2: A write with select 0 stores write-data bits [3:0] as the data-side mask, where bit i locks way i. A read with select 0 returns exactly that value in bits [3:0], with bits [31:4] zero. The new mask is in use from the cycle after the write.
- R3: A write with select 1 stores write-data bits [3:0] as the instruction-side mask, using the same bit order. A read with select 1 returns it the same way, and the data-side mask is not affected.
- R4: Select values 2 to 7 read as 0, and writes with these values change neither mask.
- R5: While a side has at least one open way, a fill request on that side returns, in the same cycle, the first way with lock bit 0 found by searching from the side's counter value upward, modulo 4.
- R6: On the clock edge after a fill, that side's counter becomes (returned way + 1) mod 4. Without a fill request the counter holds its value.
- R7: When all four lock bits of a side are 1, every fill on that side returns way 3.
- R8: A mask write in the same cycle as a fill on the same side does not affect that fill, which uses the previous mask.
- R9: Fills on one side never change the counter or the chosen way of the other side, and fills on both sides in the same cycle are each served by their own side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 = data-side mask, 1 = instruction-side mask |
| reg_wdata | input | 32 | Register write data; only bits [3:0] are stored |
| reg_rdata | output | 32 | Combinational read data for the selected register |
| d_fill_req | input | 1 | Data-side linefill request |
| d_victim | output | 2 | Way chosen for the data-side fill |
| i_fill_req | input | 1 | Instruction-side linefill request |
| i_victim | output | 2 | Way chosen for the instruction-side fill |

## Verification
The victim index and the read data depend combinationally on the current request and select, so they are due in the same cycle as the stimulus. The bench drives each cycle on the falling edge and compares a short time later, before the next rising edge. Mask writes and counter moves take effect at the next rising edge. The scoreboard model therefore computes every expected value from the state held before that edge and updates its own state only after pushing the expected values, which places each result in the cycle where it is due. The internal reset synchroniser holds the block in reset for two cycles after release, and the bench waits out those cycles before its first check.

// File: rtl/wlv_pkg.sv
package wlv_pkg;
  // Register select codes seen at the coprocessor-style port
  localparam int SEL_DSIDE = 0;
  localparam int SEL_ISIDE = 1;
  // Number of independent allocation paths (data, instruction)
  localparam int NUM_PATHS = 2;
endpackage

// File: rtl/wlv_lock_regs.sv
// Per-side lock masks with a select-addressed write/read port.
module wlv_lock_regs #(
  parameter int NUM_WAYS  = 4,
  parameter int NUM_PATHS = 2,
  parameter int SEL_W     = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [SEL_W-1:0]                    sel,
  input  logic [NUM_WAYS-1:0]                 wdata,
  output logic [NUM_WAYS-1:0]                 rdata,
  output logic [NUM_PATHS-1:0][NUM_WAYS-1:0]  mask_o
);

  logic [NUM_PATHS-1:0][NUM_WAYS-1:0] mask_q;
  logic [NUM_PATHS-1:0][NUM_WAYS-1:0] mask_d;
  logic                               mask_en;

  // Next-state: only selects that name a path take a write
  always_comb begin
    mask_d  = mask_q;
    mask_en = 1'b0;
    rdata   = '0;
    for (int p = 0; p < NUM_PATHS; p++) begin
      if (sel == SEL_W'(p)) begin
        rdata = mask_q[p];
        if (wr_en) begin
          mask_d[p] = wdata;
          mask_en   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/wlv_victim_pick.sv
// Round-robin victim search for one cache side. NUM_WAYS must be a power of two.
module wlv_victim_pick #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_req,
  input  logic [NUM_WAYS-1:0] lock_mask,
  output logic [WAY_W-1:0]    victim,
  output logic [WAY_W-1:0]    cnt_o
);

  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

  logic [WAY_W-1:0] cnt_q;
  logic [WAY_W-1:0] cnt_d;
  logic             found;
  logic [WAY_W-1:0] idx;

  // Search upward from the counter; fixed fallback when nothing is open
  always_comb begin
    victim = LAST_WAY;
    found  = 1'b0;
    idx    = '0;
    for (int k = 0; k < NUM_WAYS; k++) begin
      idx = cnt_q + WAY_W'(k);
      if (!found && !lock_mask[idx]) begin
        victim = idx;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (fill_req) begin
      cnt_d = victim + WAY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (fill_req) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/way_lock_victim_sel.sv
// Top: lock-mask registers plus one victim picker per cache side.
module way_lock_victim_sel
  import wlv_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 3,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              d_fill_req,
  output logic [WAY_W-1:0]  d_victim,
  input  logic              i_fill_req,
  output logic [WAY_W-1:0]  i_victim
);

  // Reset synchroniser: asserts asynchronously, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  logic [NUM_PATHS-1:0][NUM_WAYS-1:0] lock_mask;
  logic [NUM_WAYS-1:0]                rd_mask;
  logic [NUM_PATHS-1:0]               fill_req;
  logic [WAY_W-1:0]                   victim [NUM_PATHS];
  logic [WAY_W-1:0]                   cnt    [NUM_PATHS];
  logic                               unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_WAYS];

  wlv_lock_regs #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_PATHS(NUM_PATHS),
    .SEL_W    (SEL_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n_int),
    .wr_en (reg_wr),
    .sel   (reg_sel),
    .wdata (reg_wdata[NUM_WAYS-1:0]),
    .rdata (rd_mask),
    .mask_o(lock_mask)
  );

  assign reg_rdata = {{(DATA_W-NUM_WAYS){1'b0}}, rd_mask};

  assign fill_req[SEL_DSIDE] = d_fill_req;
  assign fill_req[SEL_ISIDE] = i_fill_req;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_side
    wlv_victim_pick #(
      .NUM_WAYS(NUM_WAYS)
    ) u_pick (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .fill_req (fill_req[p]),
      .lock_mask(lock_mask[p]),
      .victim   (victim[p]),
      .cnt_o    (cnt[p])
    );
  end

  assign d_victim = victim[SEL_DSIDE];
  assign i_victim = victim[SEL_ISIDE];

  // Named views used by the bound checker
  logic [NUM_WAYS-1:0] d_mask;
  logic [NUM_WAYS-1:0] i_mask;
  logic [WAY_W-1:0]    d_cnt;
  logic [WAY_W-1:0]    i_cnt;
  assign d_mask = lock_mask[SEL_DSIDE];
  assign i_mask = lock_mask[SEL_ISIDE];
  assign d_cnt  = cnt[SEL_DSIDE];
  assign i_cnt  = cnt[SEL_ISIDE];

endmodule

// File: rtl/wlv_checker.sv
module wlv_checker #(
  parameter int NUM_WAYS = 4,
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 3,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [SEL_W-1:0]  reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              d_fill_req,
  input logic [WAY_W-1:0]  d_victim,
  input logic              i_fill_req,
  input logic [WAY_W-1:0]  i_victim,
  input logic [NUM_WAYS-1:0] d_mask,
  input logic [NUM_WAYS-1:0] i_mask,
  input logic [WAY_W-1:0]  d_cnt,
  input logic [WAY_W-1:0]  i_cnt
);

  localparam logic [NUM_WAYS-1:0] ALL_LOCKED = '1;
  localparam logic [WAY_W-1:0]    LAST_WAY   = WAY_W'(NUM_WAYS - 1);

  p_rdata_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NUM_WAYS] == '0);

  p_dwrite_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_W'(0)) |=> d_mask == $past(reg_wdata[NUM_WAYS-1:0]));

  p_iwrite_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_W'(1)) |=> (i_mask == $past(reg_wdata[NUM_WAYS-1:0])) && $stable(d_mask));

  p_bad_sel_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel > SEL_W'(1)) |=> $stable(d_mask) && $stable(i_mask));

  p_d_open_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (d_fill_req && d_mask != ALL_LOCKED) |-> !d_mask[d_victim]);

  p_i_open_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (i_fill_req && i_mask != ALL_LOCKED) |-> !i_mask[i_victim]);

  p_d_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !d_fill_req |=> $stable(d_cnt));

  p_d_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    d_fill_req |=> d_cnt == $past(d_victim) + WAY_W'(1));

  p_d_all_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_fill_req && d_mask == ALL_LOCKED) |-> d_victim == LAST_WAY);

  p_i_all_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_fill_req && i_mask == ALL_LOCKED) |-> i_victim == LAST_WAY);

  p_i_cnt_indep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !i_fill_req |=> $stable(i_cnt));

endmodule

bind way_lock_victim_sel wlv_checker #(
  .NUM_WAYS(NUM_WAYS),
  .DATA_W  (DATA_W),
  .SEL_W   (SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .d_fill_req(d_fill_req),
  .d_victim  (d_victim),
  .i_fill_req(i_fill_req),
  .i_victim  (i_victim),
  .d_mask    (d_mask),
  .i_mask    (i_mask),
  .d_cnt     (d_cnt),
  .i_cnt     (i_cnt)
);

// File: tb/tb_way_lock_victim_sel.sv
module tb_way_lock_victim_sel;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        d_fill_req;
  logic [1:0]  d_victim;
  logic        i_fill_req;
  logic [1:0]  i_victim;

  way_lock_victim_sel dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .d_fill_req(d_fill_req),
    .d_victim  (d_victim),
    .i_fill_req(i_fill_req),
    .i_victim  (i_victim)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Scoreboard item: kind 0 = data victim, 1 = instruction victim, 2 = read data
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference model state
  logic [3:0] m_dmask, m_imask;
  logic [1:0] m_dcnt, m_icnt;

  function automatic logic [1:0] pick(input logic [3:0] mask, input logic [1:0] cnt);
    logic [1:0] idx;
    for (int k = 0; k < 4; k++) begin
      idx = cnt + 2'(k);
      if (!mask[idx]) return idx;
    end
    return 2'd3;
  endfunction

  function automatic logic [31:0] rd_model(input logic [2:0] sel);
    if (sel == 3'd0) return {28'd0, m_dmask};
    if (sel == 3'd1) return {28'd0, m_imask};
    return 32'd0;
  endfunction

  // Driver: one clock cycle of stimulus, expected values pushed from pre-edge state
  task automatic step(input logic wr, input logic [2:0] sel, input logic [31:0] wd,
                      input logic dreq, input logic ireq, input string req);
    logic [1:0] dv, iv;
    @(negedge clk);
    reg_wr     = wr;
    reg_sel    = sel;
    reg_wdata  = wd;
    d_fill_req = dreq;
    i_fill_req = ireq;
    dv = pick(m_dmask, m_dcnt);
    iv = pick(m_imask, m_icnt);
    sb_q.push_back('{2, rd_model(sel), req});
    if (dreq) sb_q.push_back('{0, {30'd0, dv}, req});
    if (ireq) sb_q.push_back('{1, {30'd0, iv}, req});
    if (dreq) m_dcnt = dv + 2'd1;
    if (ireq) m_icnt = iv + 2'd1;
    if (wr && sel == 3'd0) m_dmask = wd[3:0];
    if (wr && sel == 3'd1) m_imask = wd[3:0];
  endtask

  // Monitor: compares everything queued for this cycle, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0:       act = {30'd0, d_victim};
          1:       act = {30'd0, i_victim};
          default: act = reg_rdata;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 3'd0; reg_wdata = 32'd0;
    d_fill_req = 1'b0; i_fill_req = 1'b0;
    m_dmask = 4'h0; m_imask = 4'h0; m_dcnt = 2'd0; m_icnt = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state of masks and first victims
    step(0, 3'd0, 0, 0, 0, "R1 dmask after reset");
    step(0, 3'd1, 0, 1, 1, "R1 first fills after reset");

    // R6: open round robin on data side, with an idle gap in between
    step(0, 3'd0, 0, 1, 0, "R6 rr step");
    step(0, 3'd0, 0, 0, 0, "R6 idle hold");
    step(0, 3'd0, 0, 1, 0, "R6 rr step");
    step(0, 3'd0, 0, 1, 0, "R6 rr wrap");
    step(0, 3'd0, 0, 1, 0, "R6 rr step");

    // R2: data mask write, upper bits dropped, exact readback
    step(1, 3'd0, 32'hFFFF_FFF5, 0, 0, "R2 write dmask");
    step(0, 3'd0, 0, 0, 0, "R2 readback dmask");

    // R5: skip locked ways 0 and 2
    for (int n = 0; n < 5; n++) step(0, 3'd0, 0, 1, 0, "R5 skip locked");

    // R3 / R9: instruction mask, data mask untouched
    step(1, 3'd1, 32'h0000_00FA, 0, 0, "R3 write imask");
    step(0, 3'd1, 0, 0, 0, "R3 readback imask");
    step(0, 3'd0, 0, 0, 0, "R3 dmask unchanged");
    for (int n = 0; n < 4; n++) step(0, 3'd1, 0, 0, 1, "R9 i side fills");
    for (int n = 0; n < 3; n++) step(0, 3'd0, 0, 1, 1, "R9 both sides");

    // R4: unused selects read 0 and ignore writes
    for (int s = 2; s < 8; s++) step(1, 3'(s), 32'hFFFF_FFFF, 0, 0, "R4 bad select");
    step(0, 3'd0, 0, 1, 0, "R4 dmask kept");
    step(0, 3'd1, 0, 0, 1, "R4 imask kept");

    // R7: all locked goes to way 3
    step(1, 3'd0, 32'h0000_000F, 0, 0, "R7 lock all");
    for (int n = 0; n < 3; n++) step(0, 3'd0, 0, 1, 0, "R7 all locked way3");

    // R8: write in the fill cycle uses the old mask, new mask from the next cycle
    step(1, 3'd0, 32'h0000_0001, 1, 0, "R8 old mask in write cycle");
    step(0, 3'd0, 0, 1, 0, "R8 new mask next cycle");
    step(1, 3'd1, 32'h0000_0007, 0, 1, "R8 i side old mask");
    step(0, 3'd1, 0, 0, 1, "R8 i side new mask");
    step(0, 3'd1, 0, 0, 1, "R5 single open way");

    @(negedge clk);
    reg_wr = 1'b0; d_fill_req = 1'b0; i_fill_req = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule